// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two adaptive levels of state. The first level is a shift register that holds the outcomes of the most recent resolved branches. The second level is a table of 2-bit saturating counters. A table entry is selected by joining the history bits to a few bits of the branch address. Because the history takes part in the index, one static branch can train several counters, one for each recent path. A loop with a short fixed trip count therefore becomes fully predictable once the history is long enough to span one trip.

The lookup side is combinational. A valid fetch address is combined with the current history, and the top bit of the selected counter gives the direction. The update side takes a resolved branch address and its real outcome. At the next clock edge it moves the counter one step and shifts the outcome into the history. After reset, the table is filled with the weakly-not-taken value one entry per clock. The ready flag stays low until that fill has finished.

Top module: `twolevel_bp`

## Requirements
- R1: Each accepted update shifts its outcome into bit 0 of the history register, with 1 for taken and 0 for not taken. All other bits move up by one place and the oldest bit is discarded.
- R2: The table index is `{history[HIST_W-1:0], pc[ADDR_LSB+ADDR_W-1:ADDR_LSB]}`, with the history in the upper bits. PC bits below ADDR_LSB (the two alignment bits by default) and PC bits above the selected field do not affect the index.
- R3: `pred_taken` equals `fetch_valid & ready & counter[1]` of the counter selected by the fetch index, and it follows that counter combinationally. While `fetch_valid` is low, `pred_taken` is 0.
- R4: On a taken update, the selected counter increases by one, and a counter already at 3 stays at 3.
- R5: On a not-taken update, the selected counter decreases by one, and a counter already at 0 stays at 0.
- R6: The update index is formed from the history as it stood before the update. The new counter value and the shifted history are both visible from the next clock edge onward.
- R7: When a lookup and an update select the same entry in the same cycle, the lookup returns the counter value from before the update.
- R8: While `rst` is high and for exactly 2^(HIST_W+ADDR_W) cycles after it falls, `ready` is 0 and `pred_taken` is 0. During that time the history is cleared to 0 and every counter is set to 1, one entry per cycle. Updates presented while `ready` is 0 change neither the history nor the table.
- R9: A single loop branch with a trip count of 4 (taken three times, then not taken), trained with an 8-bit history, is predicted correctly on every execution once training has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the table fill |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| ready | output | 1 | Table fill complete; updates are accepted |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any check matters. They also assume that `upd_taken` is a known value whenever `upd_valid` is high, because the history and counter checks sample it on that condition. The stimulus holds reset from time zero and drives every input to a defined level in every cycle, including the fill window, where updates are offered on purpose to show they are dropped. Address fields are chosen so that chosen table entries can be revisited: repeated taken or not-taken outcomes pin the history to all ones or all zeros before the saturation and same-entry cases are exercised.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // Saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
    else       r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              taken_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;

  // Requires HIST_W >= 2
  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], taken_in};
  end

  assign hist_o = hist_q;

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(taken_in)); // R1

  AST_HIST_AGES: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])); // R1

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q)); // R8

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int ADDR_LSB = 2,
  localparam int IDX_W   = HIST_W + ADDR_W
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [PC_W-1:0]   pc,
  output logic [IDX_W-1:0]  idx
);

  // Only a field of the address feeds the index; the rest is dropped
  logic unused_pc_bits;
  assign unused_pc_bits = ^pc;

  assign idx = {hist, pc[ADDR_LSB +: ADDR_W]};

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int IDX_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  output ctr_t             look_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output logic             ready
);

  ctr_t             mem [DEPTH];
  logic [IDX_W-1:0] clr_idx;
  logic             clearing;

  // Fill sequencer: one entry per cycle after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_idx  <= '0;
      clearing <= 1'b1;
    end else if (clearing) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == {IDX_W{1'b1}}) clearing <= 1'b0;
    end
  end

  assign ready = ~clearing;

  // Read-modify-write on the update port
  ctr_t             upd_cur;
  logic             we;
  logic [IDX_W-1:0] wa;
  ctr_t             wd;

  assign upd_cur = mem[upd_idx];

  always_comb begin
    we = 1'b0;
    wa = upd_idx;
    wd = ctr_step(upd_cur, upd_taken);
    if (!rst) begin
      if (clearing) begin
        we = 1'b1;
        wa = clr_idx;
        wd = CTR_INIT;
      end else if (upd_en) begin
        we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // Lookup reads the stored value, so a same-cycle write is not seen
  assign look_ctr = mem[look_idx];

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R8

  AST_TOP_SAT: assert property (@(posedge clk) disable iff (rst)
    (ready && upd_en && upd_taken && upd_cur == CTR_MAX)
      |=> mem[$past(upd_idx)] == CTR_MAX); // R4

  AST_BOT_SAT: assert property (@(posedge clk) disable iff (rst)
    (ready && upd_en && !upd_taken && upd_cur == CTR_MIN)
      |=> mem[$past(upd_idx)] == CTR_MIN); // R5

  AST_FILL_VALUE: assert property (@(posedge clk) disable iff (rst)
    clearing |=> mem[$past(clr_idx)] == CTR_INIT); // R8

endmodule

// File: rtl/twolevel_bp.sv
module twolevel_bp
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int ADDR_LSB = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            ready
);

  localparam int IDX_W = HIST_W + ADDR_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  look_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr_t              look_ctr;
  logic              upd_en;
  logic              tbl_ready;

  assign upd_en = upd_valid & tbl_ready;

  bp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_en),
    .taken_in (upd_taken),
    .hist_o   (hist)
  );

  bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB))
  u_look_idx (
    .hist (hist),
    .pc   (fetch_pc),
    .idx  (look_idx)
  );

  // Pre-shift history: the register only moves at the edge
  bp_index #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB))
  u_upd_idx (
    .hist (hist),
    .pc   (upd_pc),
    .idx  (upd_idx)
  );

  bp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk       (clk),
    .rst       (rst),
    .look_idx  (look_idx),
    .look_ctr  (look_ctr),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_taken (upd_taken),
    .ready     (tbl_ready)
  );

  assign ready      = tbl_ready;
  assign pred_taken = fetch_valid & tbl_ready & look_ctr[1];

  AST_NO_PRED_UNREADY: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !pred_taken); // R8

  AST_NO_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !pred_taken); // R3

  AST_UNREADY_HOLDS_HIST: assert property (@(posedge clk) disable iff (rst)
    (!ready && upd_valid) |=> $stable(hist)); // R8

endmodule

// File: tb/tb_twolevel_bp.sv
`timescale 1ns/1ps
module tb_twolevel_bp;

  localparam int PC_W     = 32;
  localparam int HIST_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int ADDR_LSB = 2;
  localparam int DEPTH    = 1 << (HIST_W + ADDR_W);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic            pred_taken;
  logic            ready;

  always #2.5 clk = ~clk;

  twolevel_bp #(.PC_W(PC_W), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)) dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .ready(ready)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Behavioural model
  int m_ctr [DEPTH];
  int m_hist = 0;
  int m_fill = 0;

  function automatic int m_index(logic [PC_W-1:0] pc);
    int h, a;
    h = m_hist % (1 << HIST_W);
    a = int'((pc >> ADDR_LSB) % (1 << ADDR_W));
    return h * (1 << ADDR_W) + a;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare before the edge, advance model at the edge
  task automatic step(string tag, bit fv, logic [PC_W-1:0] fpc,
                      bit uv, logic [PC_W-1:0] upc, bit ut, output bit p);
    bit exp_rdy, exp_p;
    int ui;
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    exp_rdy = (m_fill >= DEPTH);
    if (!rst) check("R8 ready", int'(ready), int'(exp_rdy));
    exp_p = fv && exp_rdy && (m_ctr[m_index(fpc)] >= 2);
    if (!rst) check(tag, int'(pred_taken), int'(exp_p));
    p = pred_taken;
    @(posedge clk);
    if (rst) begin
      m_fill = 0;
      m_hist = 0;
    end else if (!exp_rdy) begin
      m_ctr[m_fill] = 1;
      m_fill++;
    end else if (uv) begin
      ui = m_index(upc);
      if (ut) begin
        if (m_ctr[ui] < 3) m_ctr[ui]++;
      end else begin
        if (m_ctr[ui] > 0) m_ctr[ui]--;
      end
      m_hist = ((m_hist * 2) + int'(ut)) % (1 << HIST_W);
    end
    @(negedge clk);
  endtask

  task automatic do_reset(int cycles);
    bit p;
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) step("R8", 1, 32'h4, 1, 32'h4, 1, p);
    rst = 1'b0;
  endtask

  // Wait out the fill, offering taken updates that must be dropped
  task automatic fill_and_count();
    bit p;
    int n = 0;
    while (!ready) begin
      step("R8 pred during fill", 1, 32'h10, 1, 32'h10, 1, p);
      n++;
    end
    check("R8 fill length", n, DEPTH);
  endtask

  localparam logic [PC_W-1:0] PC_L = 32'h0000_0100;
  localparam logic [PC_W-1:0] PC_A = 32'h0000_0004;
  localparam logic [PC_W-1:0] PC_B = 32'h0000_0008;
  localparam logic [PC_W-1:0] PC_C = 32'h0000_000C;
  localparam logic [PC_W-1:0] PC_D = 32'h0000_0014;

  initial begin
    bit p, p2;
    @(negedge clk);
    do_reset(3);
    check("R8 ready low after reset", int'(ready), 0);
    fill_and_count();

    // History cleared: entry {0,PC_L} at weak not-taken
    step("R8 init value", 1, PC_L, 0, 0, 0, p);
    check("R8 init predicts not taken", int'(p), 0);

    // R3: no prediction without fetch_valid
    step("R3", 0, PC_L, 0, 0, 0, p);
    check("R3 idle lookup", int'(p), 0);

    // R9: loop branch, trip count 4
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 4; k++) begin
        bit out;
        out = (k != 3);
        step("R6 loop train", 1, PC_L, 1, PC_L, out, p);
        if (it >= 32) check("R9 loop predicted", int'(p), int'(out));
      end
    end

    // R4: pin history to all ones, saturate {FF,A}, then two decrements
    for (int i = 0; i < 8; i++) step("R1", 1, PC_C, 1, PC_C, 1, p);
    for (int i = 0; i < 6; i++) step("R4 inc", 1, PC_A, 1, PC_A, 1, p);
    step("R4", 1, PC_A, 1, PC_A, 0, p);
    for (int i = 0; i < 8; i++) step("R1", 1, PC_C, 1, PC_C, 1, p);
    step("R4", 1, PC_A, 1, PC_A, 0, p);
    for (int i = 0; i < 8; i++) step("R1", 1, PC_C, 1, PC_C, 1, p);
    step("R4", 1, PC_A, 0, 0, 0, p);
    check("R4 saturated at 3 then down 2", int'(p), 0);

    // R5: pin history to zeros, floor {00,B}, then two increments
    for (int i = 0; i < 8; i++) step("R1", 1, PC_C, 1, PC_C, 0, p);
    for (int i = 0; i < 6; i++) step("R5 dec", 1, PC_B, 1, PC_B, 0, p);
    step("R5", 1, PC_B, 1, PC_B, 1, p);
    for (int i = 0; i < 8; i++) step("R1", 1, PC_C, 1, PC_C, 0, p);
    step("R5", 1, PC_B, 1, PC_B, 1, p);
    for (int i = 0; i < 8; i++) step("R1", 1, PC_C, 1, PC_C, 0, p);
    step("R5", 1, PC_B, 0, 0, 0, p);
    check("R5 floored at 0 then up 2", int'(p), 1);

    // R7: same entry looked up and updated together, fresh counter = 1
    step("R7", 1, PC_D, 1, PC_D, 1, p);
    check("R7 lookup sees old value", int'(p), 0);

    // R2: alignment and high address bits do not change the index
    step("R2", 1, 32'h0000_0017, 0, 0, 0, p);
    step("R2", 1, 32'hABC0_0014, 0, 0, 0, p2);
    check("R2 ignored pc bits", int'(p2), int'(p));

    // R6: mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] fpc, upc;
      fpc = {$urandom()} & 32'hFFFF_FFFF;
      upc = {$urandom()} & 32'h0000_003F;
      step("R6 random", $urandom_range(0, 3) != 0, fpc,
           $urandom_range(0, 1) == 1, upc, $urandom_range(0, 2) != 0, p);
    end

    // R8: reset mid-run clears history and table again
    do_reset(2);
    fill_and_count();
    step("R8 after second fill", 1, PC_L, 0, 0, 0, p);
    check("R8 refilled entry", int'(p), 0);
    for (int i = 0; i < 20; i++) step("R8 post-reset", 1, PC_A, 1, PC_A, 1, p);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule